// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Bank

This block is the host side of a two-channel serial controller. It holds the write registers and returns the read registers. Each channel has a control port and a data port. The host reaches a channel's internal registers in two steps. It first writes a register number to the control port. Its next control-port access then reads or writes that register. After that access the register pointer goes back to zero, so a control access made with the pointer at zero always reaches the command register.

The command register does two jobs. It carries the pointer value for the next access, and it carries a command field. The command field raises one-cycle clear pulses for that channel's error latches, external/status latches or pending transmit interrupt. One master register is shared by both channels. It holds the interrupt master enable and the vector-includes-status enable, and it can order a full reset. A full reset returns every write register to its reset value, but the 16-bit baud time constant survives it. The data port passes the receive holding byte to the host and loads the transmit holding byte. The register contents are driven out to the channel logic on a flat configuration bus.

Every access is a single-cycle strobe with no back-pressure. Read data is combinational in the cycle of the strobe. Writes, command pulses and transmit loads take effect at the clock edge that ends the strobe.

Top module: `serial_regbank`

## Requirements
- R1: `acc_sel_a`=1 addresses channel A and 0 addresses channel B. An access to one channel leaves the other channel's pointer, registers and pulses unchanged. In every per-channel vector, index 1 is channel A and index 0 is channel B.
- R2: A control write made while the pointer is 0 loads the pointer from `acc_wdata[3:0]`. Any other control access to that channel reaches the register the pointer selects and then returns the pointer to 0. Data-port accesses never move the pointer. Write register r of channel c appears on `cfg[(c*16+r)*8 +: 8]`. Slots 0 and 9 of `cfg` always read zero.
- R3: A control read at register 0 returns `rx_avail` in bit 0 and `tx_ready` in bit 2. A control read at register 1 returns `all_sent` in bit 0. All other bits of these registers read 0. Registers other than 0, 1, 12, 13 and 15 read as 0.
- R4: A control read at register 15 returns write register 15 with bits 0 and 2 forced to 0. Write register 15 resets to 8'hF8.
- R5: Registers 12 (low byte) and 13 (high byte) of the baud time constant read back exactly as written.
- R6: The command field is `acc_wdata[6:4]` of a control write made while the pointer is 0. The codes are 1 = clear external/status (`stat_clr`), 2 = clear pending transmit interrupt (`txi_clr`) and 3 = clear errors (`err_clr`). Each raises a one-cycle pulse for the addressed channel in the cycle after the write. Other codes do nothing. The pointer load in the same write still takes effect.
- R7: Register 9 is shared. A write to it through either channel sets `irq_master_en` from bit 3 and `irq_vec_status` from bit 0.
- R8: A register-9 write with bits [7:6] = 2'b11 is a full reset. It clears every write register, register 9 and both pointers to their reset values, and registers 12 and 13 of both channels keep their contents.
- R9: A data-port write loads that channel's `tx_hold` and pulses its `tx_load` in the next cycle. A data-port read returns that channel's `rx_byte` in the same cycle.
- R10: While `rst_n` is low, all registers, including the baud bytes, go to their reset values, both pointers go to 0, and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel_a | input | 1 | 1 = channel A, 0 = channel B |
| acc_ctrl | input | 1 | 1 = control port, 0 = data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid during the strobe |
| rx_byte | input | 16 | Receive holding bytes, [15:8] = A |
| rx_avail | input | 2 | Receive byte available per channel |
| tx_ready | input | 2 | Transmit buffer ready per channel |
| all_sent | input | 2 | Transmitter drained per channel |
| tx_hold | output | 16 | Transmit holding bytes, [15:8] = A |
| tx_load | output | 2 | Transmit holding byte loaded |
| err_clr | output | 2 | Clear error latches pulse |
| stat_clr | output | 2 | Clear external/status latches pulse |
| txi_clr | output | 2 | Clear pending transmit interrupt pulse |
| irq_master_en | output | 1 | Interrupt master enable |
| irq_vec_status | output | 1 | Vector-includes-status enable |
| cfg | output | 256 | Write register contents per channel |

## Verification
A single command-register write can carry a non-zero command code and a non-zero pointer value at once. The command pulse and the pointer load then land on the same clock edge. The bench provokes this directly by writing 8'h3F, then 8'h2C, on channel A. It also reaches it at random, because random command-register bytes carry both fields. After such a write it checks that exactly the expected clear pulse appeared for that channel alone. It then reads and expects the selected register, for example the masked register 15 or a baud byte, rather than the status register. A second overlap is a full-reset write that lands while the other channel's pointer is non-zero. It is judged by the next control read on that channel, which must return register 0.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int DATA_W   = 8;
  localparam int REG_N    = 16;
  localparam int CHAN_N   = 2;

  localparam int REG_CMD     = 0;
  localparam int REG_DRAIN   = 1;
  localparam int REG_MASTER  = 9;
  localparam int REG_TC_LO   = 12;
  localparam int REG_TC_HI   = 13;
  localparam int REG_IDENT   = 15;

  localparam logic [7:0] IDENT_RST  = 8'hF8;
  localparam logic [7:0] IDENT_ZERO = 8'h05;

  localparam int CMD_LSB      = 4;
  localparam int MIE_BIT      = 3;
  localparam int VIS_BIT      = 0;
  localparam int RX_AVAIL_BIT = 0;
  localparam int TX_READY_BIT = 2;
  localparam int SENT_BIT     = 0;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_CLR_STAT = 3'd1,
    CMD_CLR_TXI  = 3'd2,
    CMD_CLR_ERR  = 3'd3
  } cmd_e;

  localparam logic [1:0] FULL_RST_CODE = 2'b11;
endpackage

// File: rtl/srb_pointer.sv
module srb_pointer #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frst,
  input  logic          hit,
  input  logic          wr,
  input  logic [PW-1:0] load_val,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n || frst) begin
      ptr <= '0;
    end else if (hit) begin
      if (wr && ptr == '0) ptr <= load_val;
      else                 ptr <= '0;
    end
  end
endmodule

// File: rtl/srb_channel.sv
module srb_channel
  import srb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16,
  parameter int PW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frst,
  input  logic               ctrl_wr,
  input  logic [PW-1:0]      ptr,
  input  logic [DW-1:0]      wdata,
  input  logic               data_wr,
  output logic [NREG*DW-1:0] cfg,
  output logic               err_clr,
  output logic               stat_clr,
  output logic               txi_clr,
  output logic [DW-1:0]      tx_hold,
  output logic               tx_load
);
  logic cmd_wr;
  cmd_e cmd;

  assign cmd_wr = ctrl_wr && (ptr == '0);
  assign cmd    = cmd_e'(wdata[CMD_LSB +: 3]);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam bit          STORED = (r != REG_CMD) && (r != REG_MASTER);
    localparam bit          KEEP   = (r == REG_TC_LO) || (r == REG_TC_HI);
    localparam logic [DW-1:0] RSTV = (r == REG_IDENT) ? DW'(IDENT_RST) : '0;
    if (STORED) begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                           q <= RSTV;
        else if (frst && !KEEP)               q <= RSTV;
        else if (ctrl_wr && ptr == PW'(r))    q <= wdata;
      end
      assign cfg[r*DW +: DW] = q;
    end else begin : g_none
      assign cfg[r*DW +: DW] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_clr  <= 1'b0;
      stat_clr <= 1'b0;
      txi_clr  <= 1'b0;
      tx_load  <= 1'b0;
      tx_hold  <= '0;
    end else begin
      err_clr  <= cmd_wr && (cmd == CMD_CLR_ERR);
      stat_clr <= cmd_wr && (cmd == CMD_CLR_STAT);
      txi_clr  <= cmd_wr && (cmd == CMD_CLR_TXI);
      tx_load  <= data_wr;
      if (data_wr) tx_hold <= wdata;
    end
  end
endmodule

// File: rtl/srb_readmux.sv
module srb_readmux
  import srb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16,
  parameter int PW   = 4
) (
  input  logic               ctrl,
  input  logic [PW-1:0]      ptr,
  input  logic [NREG*DW-1:0] cfg,
  input  logic [DW-1:0]      rx_byte,
  input  logic               rx_avail,
  input  logic               tx_ready,
  input  logic               all_sent,
  output logic [DW-1:0]      rdata
);
  always_comb begin
    rdata = '0;
    if (!ctrl) begin
      rdata = rx_byte;
    end else if (ptr == PW'(REG_CMD)) begin
      rdata[RX_AVAIL_BIT] = rx_avail;
      rdata[TX_READY_BIT] = tx_ready;
    end else if (ptr == PW'(REG_DRAIN)) begin
      rdata[SENT_BIT] = all_sent;
    end else if (ptr == PW'(REG_TC_LO)) begin
      rdata = cfg[REG_TC_LO*DW +: DW];
    end else if (ptr == PW'(REG_TC_HI)) begin
      rdata = cfg[REG_TC_HI*DW +: DW];
    end else if (ptr == PW'(REG_IDENT)) begin
      rdata = cfg[REG_IDENT*DW +: DW] & ~DW'(IDENT_ZERO);
    end
  end
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import srb_pkg::*;
#(
  parameter int DW   = srb_pkg::DATA_W,
  parameter int NREG = srb_pkg::REG_N
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_en,
  input  logic                      acc_wr,
  input  logic                      acc_sel_a,
  input  logic                      acc_ctrl,
  input  logic [DW-1:0]             acc_wdata,
  output logic [DW-1:0]             acc_rdata,
  input  logic [CHAN_N*DW-1:0]      rx_byte,
  input  logic [CHAN_N-1:0]         rx_avail,
  input  logic [CHAN_N-1:0]         tx_ready,
  input  logic [CHAN_N-1:0]         all_sent,
  output logic [CHAN_N*DW-1:0]      tx_hold,
  output logic [CHAN_N-1:0]         tx_load,
  output logic [CHAN_N-1:0]         err_clr,
  output logic [CHAN_N-1:0]         stat_clr,
  output logic [CHAN_N-1:0]         txi_clr,
  output logic                      irq_master_en,
  output logic                      irq_vec_status,
  output logic [CHAN_N*NREG*DW-1:0] cfg
);
  localparam int PW   = $clog2(NREG);
  localparam int BANK = NREG * DW;

  logic [CHAN_N-1:0][PW-1:0] ptr_q;
  logic [CHAN_N-1:0]         hit;
  logic [CHAN_N-1:0]         ctrl_wr;
  logic [CHAN_N-1:0]         data_wr;
  logic [PW-1:0]             ptr_sel;
  logic                      master_wr;
  logic                      frst;
  logic [DW-1:0]             master_q;

  assign ptr_sel   = ptr_q[acc_sel_a];
  assign master_wr = acc_en && acc_ctrl && acc_wr && (ptr_sel == PW'(REG_MASTER));
  assign frst      = master_wr && (acc_wdata[DW-1 -: 2] == FULL_RST_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n || frst) master_q <= '0;
    else if (master_wr) master_q <= acc_wdata;
  end

  assign irq_master_en  = master_q[MIE_BIT];
  assign irq_vec_status = master_q[VIS_BIT];

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    assign hit[c]     = acc_en && acc_ctrl && (acc_sel_a == 1'(c));
    assign ctrl_wr[c] = hit[c] && acc_wr;
    assign data_wr[c] = acc_en && !acc_ctrl && acc_wr && (acc_sel_a == 1'(c));

    srb_pointer #(.PW(PW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .frst     (frst),
      .hit      (hit[c]),
      .wr       (acc_wr),
      .load_val (acc_wdata[PW-1:0]),
      .ptr      (ptr_q[c])
    );

    srb_channel #(.DW(DW), .NREG(NREG), .PW(PW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .frst     (frst),
      .ctrl_wr  (ctrl_wr[c]),
      .ptr      (ptr_q[c]),
      .wdata    (acc_wdata),
      .data_wr  (data_wr[c]),
      .cfg      (cfg[c*BANK +: BANK]),
      .err_clr  (err_clr[c]),
      .stat_clr (stat_clr[c]),
      .txi_clr  (txi_clr[c]),
      .tx_hold  (tx_hold[c*DW +: DW]),
      .tx_load  (tx_load[c])
    );
  end

  srb_readmux #(.DW(DW), .NREG(NREG), .PW(PW)) u_rmux (
    .ctrl     (acc_ctrl),
    .ptr      (ptr_sel),
    .cfg      (cfg[acc_sel_a*BANK +: BANK]),
    .rx_byte  (rx_byte[acc_sel_a*DW +: DW]),
    .rx_avail (rx_avail[acc_sel_a]),
    .tx_ready (tx_ready[acc_sel_a]),
    .all_sent (all_sent[acc_sel_a]),
    .rdata    (acc_rdata)
  );
endmodule

// File: rtl/srb_checker.sv
module srb_checker
  import srb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16,
  parameter int PW   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_en,
  input logic                      acc_wr,
  input logic                      acc_sel_a,
  input logic                      acc_ctrl,
  input logic [DW-1:0]             acc_wdata,
  input logic [DW-1:0]             acc_rdata,
  input logic [CHAN_N-1:0][PW-1:0] ptr_q,
  input logic [CHAN_N*DW-1:0]      tx_hold,
  input logic [CHAN_N-1:0]         tx_load,
  input logic [CHAN_N-1:0]         err_clr,
  input logic [CHAN_N-1:0]         stat_clr,
  input logic [CHAN_N-1:0]         txi_clr,
  input logic [CHAN_N*NREG*DW-1:0] cfg
);
  // R4: identification bits 0 and 2 read as zero
  a_r4_ident_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_ctrl && !acc_wr && ptr_q[acc_sel_a] == PW'(REG_IDENT))
      |-> (acc_rdata[0] == 1'b0 && acc_rdata[2] == 1'b0));

  // R2: data port never moves a pointer
  a_r2_data_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_ctrl) |=> $stable(ptr_q));

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chk
    // R2: register access sends the pointer home
    a_r2_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_ctrl && acc_sel_a == 1'(c) && ptr_q[c] != '0) |=> (ptr_q[c] == '0));

    // R6: at most one clear pulse per channel
    a_r6_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_clr[c], stat_clr[c], txi_clr[c]}));

    // R6: pulses only follow a command-register write on this channel
    a_r6_cmd_source: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr[c] || stat_clr[c] || txi_clr[c])
        |-> $past(acc_en && acc_ctrl && acc_wr && acc_sel_a == 1'(c) && ptr_q[c] == '0));

    // R9: transmit load follows a data write with its byte
    a_r9_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load[c] |-> ($past(acc_en && acc_wr && !acc_ctrl && acc_sel_a == 1'(c))
                      && tx_hold[c*DW +: DW] == $past(acc_wdata)));

    // R8: baud bytes survive a full reset
    a_r8_baud_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_ctrl && acc_wr && ptr_q[acc_sel_a] == PW'(REG_MASTER)
        && acc_wdata[DW-1 -: 2] == FULL_RST_CODE)
        |=> $stable(cfg[(c*NREG + REG_TC_LO)*DW +: 2*DW]));
  end
endmodule

bind serial_regbank srb_checker #(.DW(DW), .NREG(NREG), .PW(PW)) u_srb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_sel_a (acc_sel_a),
  .acc_ctrl  (acc_ctrl),
  .acc_wdata (acc_wdata),
  .acc_rdata (acc_rdata),
  .ptr_q     (ptr_q),
  .tx_hold   (tx_hold),
  .tx_load   (tx_load),
  .err_clr   (err_clr),
  .stat_clr  (stat_clr),
  .txi_clr   (txi_clr),
  .cfg       (cfg)
);

// File: tb/test_serial_regbank.sv
module test_serial_regbank;
  localparam int DW = 8;
  localparam int NREG = 16;
  localparam int CW = 2 * NREG * DW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, acc_en, acc_wr, acc_sel_a, acc_ctrl;
  logic [7:0]    acc_wdata, acc_rdata;
  logic [15:0]   rx_byte, tx_hold;
  logic [1:0]    rx_avail, tx_ready, all_sent, tx_load, err_clr, stat_clr, txi_clr;
  logic          irq_master_en, irq_vec_status;
  logic [CW-1:0] cfg;

  serial_regbank i_serial_regbank (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] ew [2][NREG];
  logic [7:0] ew9;
  logic [3:0] eptr [2];
  logic [7:0] ehold [2];

  task automatic chk(string tag, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset(bit hw);
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < NREG; r++)
        if (hw || (r != 12 && r != 13)) ew[c][r] = (r == 15) ? 8'hF8 : 8'h00;
      eptr[c] = '0;
      if (hw) ehold[c] = '0;
    end
    ew9 = '0;
  endtask

  function automatic logic [CW-1:0] exp_cfg();
    logic [CW-1:0] v = '0;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NREG; r++)
        if (r != 0 && r != 9) v[(c*NREG+r)*DW +: DW] = ew[c][r];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(int c, int p);
    logic [7:0] v = '0;
    case (p)
      0:  begin v[0] = rx_avail[c]; v[2] = tx_ready[c]; end
      1:  v[0] = all_sent[c];
      12, 13: v = ew[c][p];
      15: v = ew[c][15] & 8'hFA;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic acc(bit ch, bit ctrl, bit wr, logic [7:0] d, output logic [7:0] rd);
    logic [1:0] e_err, e_stat, e_txi, e_load;
    int p;
    string tag;
    e_err = '0; e_stat = '0; e_txi = '0; e_load = '0;
    @(negedge clk);
    acc_en = 1'b1; acc_sel_a = ch; acc_ctrl = ctrl; acc_wr = wr; acc_wdata = d;
    #5;
    rd = acc_rdata;
    p = int'(eptr[ch]);
    if (ctrl) begin
      if (wr) begin
        if (p == 0) begin
          eptr[ch] = d[3:0];
          case (d[6:4])
            3'd1: e_stat[ch] = 1'b1;
            3'd2: e_txi[ch]  = 1'b1;
            3'd3: e_err[ch]  = 1'b1;
            default: ;
          endcase
        end else if (p == 9) begin
          if (d[7:6] == 2'b11) model_reset(1'b0);
          else begin ew9 = d; eptr[ch] = '0; end
        end else begin
          ew[ch][p] = d;
          eptr[ch] = '0;
        end
      end else begin
        tag = (p == 15) ? "R4" : (p == 12 || p == 13) ? "R5" : "R3";
        chk(tag, $sformatf("read reg %0d ch %0d", p, ch), CW'(rd), CW'(exp_read(ch, p)));
        eptr[ch] = '0;
      end
    end else if (wr) begin
      e_load[ch] = 1'b1;
      ehold[ch] = d;
    end else begin
      chk("R9", "data read", CW'(rd), CW'(rx_byte[ch*8 +: 8]));
    end
    @(posedge clk);
    #1;
    acc_en = 1'b0;
    chk("R6", "clear pulses {err,stat,txi}", CW'({err_clr, stat_clr, txi_clr}), CW'({e_err, e_stat, e_txi}));
    chk("R9", "tx_load", CW'(tx_load), CW'(e_load));
    chk("R9", "tx_hold", CW'(tx_hold), CW'({ehold[1], ehold[0]}));
    chk("R2", "cfg bus", cfg, exp_cfg());
    chk("R7", "irq enables", CW'({irq_master_en, irq_vec_status}), CW'({ew9[3], ew9[0]}));
  endtask

  task automatic wreg(bit ch, int r, logic [7:0] d);
    logic [7:0] rd;
    acc(ch, 1'b1, 1'b1, 8'(r), rd);
    acc(ch, 1'b1, 1'b1, d, rd);
  endtask

  task automatic rreg(bit ch, int r, output logic [7:0] rd);
    logic [7:0] tmp;
    acc(ch, 1'b1, 1'b1, 8'(r), tmp);
    acc(ch, 1'b1, 1'b0, 8'h00, rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5EED_0A17));
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_sel_a = 1'b0; acc_ctrl = 1'b0;
    acc_wdata = '0; rx_byte = 16'hA55A; rx_avail = 2'b10; tx_ready = 2'b01; all_sent = 2'b11;
    model_reset(1'b1);
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "reset cfg", cfg, exp_cfg());
    chk("R10", "reset outputs", CW'({tx_hold, tx_load, err_clr, stat_clr, txi_clr, irq_master_en, irq_vec_status}), '0);
    @(negedge clk);
    rst_n = 1'b1;

    rreg(1'b1, 15, rd);
    chk("R10", "ident after reset", CW'(rd), CW'(8'hF8));
    // R5: baud bytes
    wreg(1'b1, 12, 8'h34);
    wreg(1'b1, 13, 8'hC7);
    wreg(1'b0, 12, 8'hFF);
    rreg(1'b1, 12, rd);
    rreg(1'b1, 13, rd);
    chk("R5", "baud hi A", CW'(rd), CW'(8'hC7));
    // R4: masked identification bits
    wreg(1'b1, 15, 8'hFF);
    rreg(1'b1, 15, rd);
    chk("R4", "ident all ones", CW'(rd), CW'(8'hFA));
    // R6: command and pointer in the same write
    acc(1'b1, 1'b1, 1'b1, 8'h3F, rd);
    acc(1'b1, 1'b1, 1'b0, 8'h00, rd);
    chk("R6", "read after cmd+ptr", CW'(rd), CW'(8'hFA));
    acc(1'b1, 1'b1, 1'b1, 8'h2C, rd);
    acc(1'b1, 1'b1, 1'b0, 8'h00, rd);
    acc(1'b0, 1'b1, 1'b1, 8'h10, rd);
    acc(1'b0, 1'b1, 1'b1, 8'h70, rd);
    // R1: channel B access leaves A's pointer alone
    acc(1'b1, 1'b1, 1'b1, 8'h0C, rd);
    acc(1'b0, 1'b1, 1'b0, 8'h00, rd);
    chk("R1", "B status read", CW'(rd), CW'(8'h04));
    acc(1'b1, 1'b1, 1'b0, 8'h00, rd);
    chk("R1", "A pointer kept", CW'(rd), CW'(8'h34));
    // R2: data port does not move the pointer
    acc(1'b1, 1'b1, 1'b1, 8'h0D, rd);
    acc(1'b1, 1'b0, 1'b1, 8'h77, rd);
    acc(1'b1, 1'b0, 1'b0, 8'h00, rd);
    chk("R9", "rx byte A", CW'(rd), CW'(8'hA5));
    acc(1'b1, 1'b1, 1'b0, 8'h00, rd);
    chk("R2", "pointer held across data", CW'(rd), CW'(8'hC7));
    // R7: shared register written from B
    wreg(1'b0, 9, 8'h09);
    // R8: full reset while B pointer non-zero
    acc(1'b0, 1'b1, 1'b1, 8'h0F, rd);
    wreg(1'b1, 9, 8'hC0);
    acc(1'b0, 1'b1, 1'b0, 8'h00, rd);
    chk("R8", "B pointer cleared", CW'(rd), CW'(8'h04));
    rreg(1'b1, 12, rd);
    chk("R8", "baud lo kept", CW'(rd), CW'(8'h34));
    rreg(1'b1, 15, rd);
    chk("R8", "ident reset", CW'(rd), CW'(8'hF8));

    for (int i = 0; i < 1500; i++) begin
      bit ch, ctrl, wr;
      logic [7:0] d;
      rx_byte = 16'($urandom); rx_avail = 2'($urandom); tx_ready = 2'($urandom); all_sent = 2'($urandom);
      ch = 1'($urandom); ctrl = ($urandom % 5) != 0; wr = 1'($urandom); d = 8'($urandom);
      acc(ch, ctrl, wr, d, rd);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule